// File: doc/BRIEF.md
# Six-Channel Sample Address Sequencer

This block walks sample memory for six independent playback channels. Software programs a 16-bit start page and a 16-bit stop page for each channel. A page is 256 bytes. A key register then starts or stops any group of channels with a single write. While a channel is playing, its byte pointer steps through memory, one byte for each turn it receives. A single shared request strobe grants turns to the playing channels in rotating order. Each turn produces one read address on an address/valid output, tagged with the channel that owns it.

A channel stops by itself once it has fetched the final byte of its stop page. At that point it raises an end flag. The flag stays set until software clears it. A separate flag-control write clears and masks these flags: a 1 clears the flag and masks it, and a 0 removes the mask. Keying a channel on again leaves its flag as it is. Decoding of the fetched bytes, volume and panning are handled elsewhere.

Top module: `sample_seq_top`

## Requirements
- R1: After reset, `rd_valid` and `end_flags` are 0, no channel plays, and every start and stop page register holds 0. A channel keyed on straight after reset therefore fetches from byte address 0x000000 up to 0x0000FF.
- R2: A write to register address 0x00 is a key command. Data bit 7 is the dump bit and bits 5..0 select channels 6..1 (bit i selects channel i+1). With dump 0, the selected channels start. With dump 1, they stop. Channels that are not selected keep their state.
- R3: Channel i+1 (i = 0..5) takes its start page low byte at address 0x10+i and its high byte at 0x18+i. Its stop page low byte is at 0x20+i and its high byte at 0x28+i. Byte addresses are the page value shifted left by 8.
- R4: A cycle with `req_strobe` high while at least one channel plays gives exactly one fetch. In that case `rd_valid` is high in the following cycle only. A strobe while no channel plays gives no fetch.
- R5: Turns rotate among the playing channels. Each strobe serves the next playing channel after the one served last, in increasing index order with wrap-around. After reset the search begins at channel 1.
- R6: Each fetch presents the channel's current byte address on `rd_addr` and its zero-based index on `rd_ch`. The pointer then advances by one. A channel that has just fetched byte (stop<<8)|0xFF stops playing.
- R7: When a channel stops at its stop page, `end_flags` bit i (channel i+1) goes high in the same cycle as that last `rd_valid`, unless the flag is masked.
- R8: A flag-control write (`flag_wr`) with data bit i = 1 clears flag i and masks it. Data bit i = 0 removes the mask and leaves the flag unchanged.
- R9: End flags are sticky. Only a flag-control write clears them, and keying the channel on again does not.
- R10: Keying on a channel that is already playing restarts it from its start page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| flag_wr | input | 1 | Flag-control write strobe |
| flag_data | input | 6 | Flag-control data, one bit per channel |
| req_strobe | input | 1 | Shared request for one byte fetch |
| rd_valid | output | 1 | Fetch address valid |
| rd_addr | output | 24 | Fetch byte address |
| rd_ch | output | 3 | Channel index of the fetch |
| end_flags | output | 6 | Sticky end flags, channels 6..1 on bits 5..0 |

## Verification
The bench uses the default build: six channels, 16-bit pages and 256-byte pages. With these values a full page takes 256 strobes, so each run reaches its natural end and the final-byte comparison within a few thousand cycles. Six channels make the rotation wrap through gaps in the set of playing channels. The 16-bit page width lets the bench check that the high and low register bytes are placed correctly. Because the stop page can be one above the start page, a walk also has to cross a page carry.

// File: rtl/sample_seq_pkg.sv
package sample_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int PAGE_W = 2 * BYTE_W;
  localparam int PTR_W  = PAGE_W + BYTE_W;
  localparam int DUMP_BIT = 7;

  localparam logic [7:0] KEY_REG_ADDR  = 8'h00;
  localparam logic [7:0] START_LO_BASE = 8'h10;
  localparam logic [7:0] START_HI_BASE = 8'h18;
  localparam logic [7:0] STOP_LO_BASE  = 8'h20;
  localparam logic [7:0] STOP_HI_BASE  = 8'h28;
endpackage

// File: rtl/sample_seq_regs.sv
module sample_seq_regs
  import sample_seq_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [7:0]                     wr_addr,
  input  logic [BYTE_W-1:0]              wr_data,
  output logic [NUM_CH-1:0][PAGE_W-1:0]  start_pg,
  output logic [NUM_CH-1:0][PAGE_W-1:0]  stop_pg,
  output logic [NUM_CH-1:0]              key_on,
  output logic [NUM_CH-1:0]              key_off
);

  logic key_sel;

  always_comb begin
    key_sel = wr_en && (wr_addr == KEY_REG_ADDR);
    key_on  = '0;
    key_off = '0;
    if (key_sel) begin
      if (wr_data[DUMP_BIT]) key_off = wr_data[NUM_CH-1:0];
      else                   key_on  = wr_data[NUM_CH-1:0];
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_page
    logic [BYTE_W-1:0] s_lo_q, s_lo_d, s_hi_q, s_hi_d;
    logic [BYTE_W-1:0] e_lo_q, e_lo_d, e_hi_q, e_hi_d;

    always_comb begin
      s_lo_d = s_lo_q;
      s_hi_d = s_hi_q;
      e_lo_d = e_lo_q;
      e_hi_d = e_hi_q;
      if (wr_en) begin
        if (wr_addr == START_LO_BASE + 8'(ch)) s_lo_d = wr_data;
        if (wr_addr == START_HI_BASE + 8'(ch)) s_hi_d = wr_data;
        if (wr_addr == STOP_LO_BASE  + 8'(ch)) e_lo_d = wr_data;
        if (wr_addr == STOP_HI_BASE  + 8'(ch)) e_hi_d = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_lo_q <= '0;
        s_hi_q <= '0;
        e_lo_q <= '0;
        e_hi_q <= '0;
      end else begin
        s_lo_q <= s_lo_d;
        s_hi_q <= s_hi_d;
        e_lo_q <= e_lo_d;
        e_hi_q <= e_hi_d;
      end
    end

    assign start_pg[ch] = {s_hi_q, s_lo_q};
    assign stop_pg[ch]  = {e_hi_q, e_lo_q};
  end

  // R2: a key command never both starts and stops the same channel
  p_key_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_on & key_off) == '0);

endmodule

// File: rtl/sample_seq_chan.sv
module sample_seq_chan
  import sample_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_on,
  input  logic              key_off,
  input  logic              grant,
  input  logic [PAGE_W-1:0] start_pg,
  input  logic [PAGE_W-1:0] stop_pg,
  output logic              active,
  output logic [PTR_W-1:0]  ptr,
  output logic              end_pulse
);

  logic             active_q, active_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             at_last;

  always_comb begin
    at_last   = (ptr_q == {stop_pg, {BYTE_W{1'b1}}});
    active_d  = active_q;
    ptr_d     = ptr_q;
    end_pulse = 1'b0;
    if (key_on) begin
      active_d = 1'b1;
      ptr_d    = {start_pg, {BYTE_W{1'b0}}};
    end else if (key_off) begin
      active_d = 1'b0;
    end else if (grant && active_q) begin
      if (at_last) begin
        active_d  = 1'b0;
        end_pulse = 1'b1;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ptr_q    <= '0;
    end else begin
      active_q <= active_d;
      ptr_q    <= ptr_d;
    end
  end

  assign active = active_q;
  assign ptr    = ptr_q;

  // R6: the fetch of the last byte ends playback
  p_end_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |=> !active_q);

  // R10: key-on (re)loads the pointer from the start page
  p_keyon_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    key_on |=> (active_q && ptr_q == {$past(start_pg), {BYTE_W{1'b0}}}));

  // R6: a granted, non-final fetch advances the pointer by one
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && active_q && !at_last && !key_on && !key_off)
      |=> (ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/sample_seq_arb.sv
module sample_seq_arb #(
  parameter int NUM_CH = 6,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [NUM_CH-1:0] active,
  output logic [NUM_CH-1:0] grant,
  output logic              fetch,
  output logic [CH_W-1:0]   sel
);

  logic [CH_W-1:0] last_q, last_d;
  logic            found;

  always_comb begin
    int idx;
    found = 1'b0;
    sel   = '0;
    for (int k = 1; k <= NUM_CH; k++) begin
      idx = int'(last_q) + k;
      if (idx >= NUM_CH) idx = idx - NUM_CH;
      if (!found && active[idx]) begin
        found = 1'b1;
        sel   = CH_W'(idx);
      end
    end
    fetch = req && found;
    grant = '0;
    if (fetch) grant[sel] = 1'b1;
    last_d = fetch ? sel : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= CH_W'(NUM_CH - 1);
    else        last_q <= last_d;
  end

  // R5: at most one channel is served per strobe
  p_one_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R4: a grant only ever goes to a playing channel
  p_grant_playing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~active) == '0);

endmodule

// File: rtl/sample_seq_flags.sv
module sample_seq_flags #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_wr,
  input  logic [NUM_CH-1:0] flag_data,
  input  logic [NUM_CH-1:0] end_pulse,
  output logic [NUM_CH-1:0] end_flags
);

  logic [NUM_CH-1:0] flag_q, flag_d, mask_q, mask_d, clr;

  always_comb begin
    clr    = flag_wr ? flag_data : '0;
    mask_d = flag_wr ? flag_data : mask_q;
    flag_d = (flag_q & ~clr) | (end_pulse & ~mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

  assign end_flags = flag_q;

  // R8: a written 1 leaves that flag clear in the next cycle
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> (end_flags & $past(flag_data)) == '0);

  // R9: without a flag-control write no flag ever drops
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> (end_flags & $past(end_flags)) == $past(end_flags));

  // R7: a flag rises only with an end event
  p_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_d & ~flag_q) & ~end_pulse) == '0);

endmodule

// File: rtl/sample_seq_top.sv
module sample_seq_top
  import sample_seq_pkg::*;
#(
  parameter int NUM_CH = 6,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              flag_wr,
  input  logic [NUM_CH-1:0] flag_data,
  input  logic              req_strobe,
  output logic              rd_valid,
  output logic [PTR_W-1:0]  rd_addr,
  output logic [CH_W-1:0]   rd_ch,
  output logic [NUM_CH-1:0] end_flags
);

  logic [NUM_CH-1:0][PAGE_W-1:0] start_pg, stop_pg;
  logic [NUM_CH-1:0][PTR_W-1:0]  ptr;
  logic [NUM_CH-1:0]             key_on, key_off, active, grant, end_pulse;
  logic                          fetch;
  logic [CH_W-1:0]               sel;

  logic             rd_valid_q, rd_valid_d;
  logic [PTR_W-1:0] rd_addr_q, rd_addr_d;
  logic [CH_W-1:0]  rd_ch_q, rd_ch_d;

  sample_seq_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .start_pg (start_pg),
    .stop_pg  (stop_pg),
    .key_on   (key_on),
    .key_off  (key_off)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    sample_seq_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_on    (key_on[ch]),
      .key_off   (key_off[ch]),
      .grant     (grant[ch]),
      .start_pg  (start_pg[ch]),
      .stop_pg   (stop_pg[ch]),
      .active    (active[ch]),
      .ptr       (ptr[ch]),
      .end_pulse (end_pulse[ch])
    );
  end

  sample_seq_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req_strobe),
    .active (active),
    .grant  (grant),
    .fetch  (fetch),
    .sel    (sel)
  );

  sample_seq_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .flag_wr   (flag_wr),
    .flag_data (flag_data),
    .end_pulse (end_pulse),
    .end_flags (end_flags)
  );

  always_comb begin
    rd_valid_d = fetch;
    rd_addr_d  = fetch ? ptr[sel] : rd_addr_q;
    rd_ch_d    = fetch ? sel : rd_ch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_addr_q  <= '0;
      rd_ch_q    <= '0;
    end else begin
      rd_valid_q <= rd_valid_d;
      rd_addr_q  <= rd_addr_d;
      rd_ch_q    <= rd_ch_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_addr  = rd_addr_q;
  assign rd_ch    = rd_ch_q;

  // R4: a strobe with a playing channel yields a fetch next cycle
  p_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_strobe && |active) |=> rd_valid);

  // R4: no strobe or nothing playing yields no fetch
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_strobe && |active) |=> !rd_valid);

endmodule

// File: tb/sample_seq_top_tb_top.sv
module sample_seq_top_tb_top;
  localparam int NCH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        flag_wr = 1'b0;
  logic [5:0]  flag_data = '0;
  logic        req_strobe = 1'b0;
  logic        rd_valid;
  logic [23:0] rd_addr;
  logic [2:0]  rd_ch;
  logic [5:0]  end_flags;

  always #2 clk = ~clk;

  sample_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .flag_wr(flag_wr), .flag_data(flag_data),
    .req_strobe(req_strobe), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ch(rd_ch), .end_flags(end_flags)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model
  logic [15:0] m_start [NCH];
  logic [15:0] m_stop  [NCH];
  logic [23:0] m_ptr   [NCH];
  bit          m_act   [NCH];
  int          m_last;
  logic [5:0]  m_mask, m_flag;
  logic [26:0] exp_q [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a >= 8'h10 && a <= 8'h15) m_start[a-8'h10][7:0]  = d;
    if (a >= 8'h18 && a <= 8'h1D) m_start[a-8'h18][15:8] = d;
    if (a >= 8'h20 && a <= 8'h25) m_stop[a-8'h20][7:0]   = d;
    if (a >= 8'h28 && a <= 8'h2D) m_stop[a-8'h28][15:8]  = d;
    if (a == 8'h00)
      for (int i = 0; i < NCH; i++)
        if (d[i]) begin
          if (d[7]) m_act[i] = 1'b0;
          else begin m_act[i] = 1'b1; m_ptr[i] = {m_start[i], 8'h00}; end
        end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ch(input int c, input logic [15:0] s, input logic [15:0] e);
    wr(8'h10 + 8'(c), s[7:0]);  wr(8'h18 + 8'(c), s[15:8]);
    wr(8'h20 + 8'(c), e[7:0]);  wr(8'h28 + 8'(c), e[15:8]);
  endtask

  task automatic fwr(input logic [5:0] d);
    @(negedge clk);
    flag_wr = 1'b1; flag_data = d;
    m_flag = m_flag & ~d; m_mask = d;
    @(negedge clk);
    flag_wr = 1'b0;
  endtask

  task automatic strobe();
    bit got;
    @(negedge clk);
    req_strobe = 1'b1;
    got = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      int idx;
      idx = (m_last + k) % NCH;
      if (!got && m_act[idx]) begin
        got = 1'b1;
        m_last = idx;
        exp_q.push_back({3'(idx), m_ptr[idx]});
        if (m_ptr[idx] == {m_stop[idx], 8'hFF}) begin
          m_act[idx] = 1'b0;
          if (!m_mask[idx]) m_flag[idx] = 1'b1;
        end else m_ptr[idx] = m_ptr[idx] + 1'b1;
      end
    end
    @(negedge clk);
    req_strobe = 1'b0;
  endtask

  task automatic drain_check(input string req);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, {req, " pending fetches"}, exp_q.size(), 0);
    chk(end_flags == m_flag, {req, " end_flags"}, end_flags, m_flag);
  endtask

  // monitor: pops expected fetches as the design produces them
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected fetch", rd_addr, 0);
        else begin
          logic [26:0] e;
          e = exp_q.pop_front();
          chk(rd_addr == e[23:0], "R3 R5 R6 rd_addr", rd_addr, e[23:0]);
          chk(rd_ch == e[26:24], "R5 rd_ch", rd_ch, e[26:24]);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      m_start[i] = '0; m_stop[i] = '0; m_ptr[i] = '0; m_act[i] = 1'b0;
    end
    m_last = NCH - 1; m_mask = '0; m_flag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(end_flags == 6'h00, "R1 end_flags", end_flags, 0);
    // R4: strobe while nothing plays
    strobe();
    drain_check("R4 idle strobe");
    // R1 R2 R6 R7: channel 6 with reset pages plays 0x000000..0x0000FF
    wr(8'h00, 8'h20);
    repeat (257) strobe();
    drain_check("R7 ch6 end");
    chk(end_flags[5] == 1'b1, "R7 ch6 flag", end_flags[5], 1);
    // R9: key-on again keeps the flag, R2: dump stops it
    wr(8'h00, 8'h20);
    repeat (5) strobe();
    drain_check("R9 sticky on rekey");
    chk(end_flags[5] == 1'b1, "R9 flag kept", end_flags[5], 1);
    wr(8'h00, 8'hA0);
    repeat (3) strobe();
    drain_check("R2 dump stop");
    // R3 R5: three channels with distinct pages, ch1 masked (R8)
    set_ch(0, 16'h1234, 16'h1234);
    set_ch(2, 16'hABCD, 16'hABCE);
    set_ch(3, 16'h0102, 16'h0102);
    fwr(6'h01);
    drain_check("R8 mask no clear");
    wr(8'h00, 8'h0D);
    repeat (20) strobe();
    // R10: restart channel 3 mid-play
    wr(8'h00, 8'h04);
    repeat (20) strobe();
    // R2: stop channel 4 only
    wr(8'h00, 8'h88);
    repeat (800) strobe();
    drain_check("R5 R6 R7 R8 mixed run");
    chk(end_flags[0] == 1'b0, "R8 masked ch1", end_flags[0], 0);
    chk(end_flags[2] == 1'b1, "R7 ch3 flag", end_flags[2], 1);
    chk(end_flags[3] == 1'b0, "R2 ch4 stopped early", end_flags[3], 0);
    // R8: clear plus mask, then unmask keeps flags clear
    fwr(6'h24);
    drain_check("R8 clear");
    fwr(6'h00);
    drain_check("R8 unmask");
    chk(end_flags == 6'h00, "R8 flags clear", end_flags, 0);
    wr(8'h00, 8'h01);
    repeat (260) strobe();
    drain_check("R7 unmasked ch1");
    chk(end_flags[0] == 1'b1, "R7 ch1 flag", end_flags[0], 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule